// File: doc/BRIEF.md
# BCD Calendar Clock with Snapshot

This block keeps a time-of-day and calendar in packed BCD. It is paced by a single-cycle `tick` enable that arrives at the time-base rate (nominally 32768 per second). A fractional accumulator turns those ticks into exactly `SUB_HZ` hundredth-second steps per second. The counted fields are hundredths, seconds, minutes, hours in 24-hour form, day of week, date, month, year and a 2-bit century. Month lengths and leap years are followed automatically.

Two copies of the eight time bytes exist. The internal copy counts and receives register writes. The user copy is what `rd_data` shows. On every clock edge where `freeze` was low, the whole internal image moves into the user copy in one transfer. While `freeze` is high, the user copy holds still, so a multi-byte read sees one coherent instant while time keeps advancing underneath.

Any write restarts the sub-second phase. A stop bit halts counting. Several control bits sit in otherwise unused bits of the time bytes. They ride along untouched.

Top module: `bcd_calendar_clock`

Register image (address: content, BCD unless noted):
- 0: hundredths
- 1: bit 7 stop, bits 6:0 seconds
- 2: bit 7 fail-interrupt enable, bits 6:0 minutes
- 3: bits 7:6 spare, bits 5:0 hours
- 4: bits 7:3 spare, bits 2:0 weekday 1..7
- 5: bits 7:6 spare, bits 5:0 date
- 6: bits 7:6 century (binary), bit 5 spare, bits 4:0 month
- 7: year

## Requirements
- R1: After reset every byte reads 00h except weekday (address 4), date (address 5) and month (address 6), which read 01h.
- R2: Hundredths advance by exactly SUB_HZ steps for every TICK_HZ ticks. Each step comes on the tick where the running sum of SUB_HZ per tick reaches TICK_HZ; that threshold is then subtracted from the sum.
- R3: Seconds and minutes wrap 59 to 00, and hours wrap 23 to 00, each carrying into the next field. At midnight the weekday goes from 7 back to 1 and otherwise increments.
- R4: At midnight the date wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months. In month 02 it wraps after day 29 when the BCD year is divisible by 4, and after day 28 otherwise.
- R5: Month wraps 12 to 01 and increments the year. Year wraps 99 to 00 and increments the century (address 6, bits 7:6) modulo 4.
- R6: A write loads the addressed byte and forces hundredths to 00. A nonzero value written to address 0 is stored as 00. The sub-second phase restarts, so the next hundredth step needs the full tick count from zero.
- R7: While address 1 bit 7 is 1, no field changes except by writes. Writing it back to 0 resumes counting.
- R8: The stop bit, the fail-interrupt enable, and the spare bits listed above keep their written values through all counting and read back unchanged.
- R9: The user copy takes the internal image on each clock edge at which `freeze` was low. It holds its value across edges at which `freeze` was high, including after writes made during the freeze.
- R10: `rd_data` combinationally shows the user-copy byte selected by `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle time-base enable |
| wr_en | input | 1 | Write strobe for one byte |
| wr_addr | input | 3 | Write byte address |
| wr_data | input | 8 | Write byte value |
| freeze | input | 1 | Hold the user copy |
| rd_addr | input | 3 | Read byte address |
| rd_data | output | 8 | User-copy byte at rd_addr |

## Verification
The bench builds the clock with TICK_HZ = 250 and SUB_HZ = 100. This gives 2.5 ticks per hundredth, so the accumulator alternates 3- and 2-tick periods and exercises the fractional path that 32768/100 uses. A full second takes only 250 ticks, which puts midnight, month-end, leap-February and century rollovers within a few hundred cycles of a preset time. The spare bits are loaded with ones during a full rollover to show they survive it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int RTC_NREG = 8;
  localparam int RTC_AW   = $clog2(RTC_NREG);

  // reset image, index 7 (year) first
  localparam logic [RTC_NREG-1:0][7:0] RTC_RESET_IMG =
    {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00};

  // bits that counting must never alter
  localparam logic [RTC_NREG-1:0][7:0] RTC_KEEP_MASK =
    {8'h00, 8'h20, 8'hC0, 8'hF8, 8'hC0, 8'h80, 8'h80, 8'h00};

  typedef struct packed {
    logic [7:0] val;
    logic       wrap;
  } step_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic step_t bcd_step(input logic [7:0] cur,
                                     input logic [7:0] top,
                                     input logic [7:0] bottom,
                                     input logic       en);
    step_t r;
    r.val  = cur;
    r.wrap = 1'b0;
    if (en) begin
      if (cur >= top) begin
        r.val  = bottom;
        r.wrap = 1'b1;
      end else begin
        r.val = bcd_inc(cur);
      end
    end
    return r;
  endfunction

  // 10 = 2 mod 4, so (2*tens + ones) mod 4 decides
  function automatic logic year_is_leap(input logic [7:0] y);
    logic [1:0] r;
    r = {y[4], 1'b0} + y[1:0];
    return (r == 2'd0);
  endfunction

  function automatic logic [7:0] month_len(input logic [4:0] m, input logic leap);
    case (m)
      5'h02:                     return leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                   return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_subsec_div.sv
module rtc_subsec_div #(
  parameter int TICK_HZ = 32768,
  parameter int SUB_HZ  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic clear,
  output logic sub_pulse
);
  localparam int ACC_W = $clog2(TICK_HZ + SUB_HZ + 1);
  localparam logic [ACC_W-1:0] STEP  = ACC_W'(SUB_HZ);
  localparam logic [ACC_W-1:0] LIMIT = ACC_W'(TICK_HZ);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum;

  assign sum       = acc + STEP;
  assign sub_pulse = tick && run && !clear && (sum >= LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n)           acc <= '0;
    else if (clear)       acc <= '0;
    else if (tick && run) acc <= sub_pulse ? (sum - LIMIT) : sum;
  end

  generate
    if (TICK_HZ >= 2 * SUB_HZ) begin : g_gap_chk
      // R2
      sub_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sub_pulse |=> !sub_pulse);
    end
  endgenerate
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sub_pulse,
  input  logic                        wr_en,
  input  logic [RTC_AW-1:0]           wr_addr,
  input  logic [7:0]                  wr_data,
  output logic [RTC_NREG-1:0][7:0]    live,
  output logic                        stopped
);
  step_t s_hs, s_se, s_mi, s_hr, s_dw, s_dt, s_mo, s_yr;
  logic [7:0] mlen;
  logic [1:0] cen_nxt;
  logic [RTC_NREG-1:0][7:0] counted, nxt;

  assign stopped = live[1][7];

  always_comb begin
    mlen = month_len(live[6][4:0], year_is_leap(live[7]));
    s_hs = bcd_step(live[0],                8'h99, 8'h00, sub_pulse);
    s_se = bcd_step({1'b0, live[1][6:0]},   8'h59, 8'h00, s_hs.wrap);
    s_mi = bcd_step({1'b0, live[2][6:0]},   8'h59, 8'h00, s_se.wrap);
    s_hr = bcd_step({2'b0, live[3][5:0]},   8'h23, 8'h00, s_mi.wrap);
    s_dw = bcd_step({5'b0, live[4][2:0]},   8'h07, 8'h01, s_hr.wrap);
    s_dt = bcd_step({2'b0, live[5][5:0]},   mlen,  8'h01, s_hr.wrap);
    s_mo = bcd_step({3'b0, live[6][4:0]},   8'h12, 8'h01, s_dt.wrap);
    s_yr = bcd_step(live[7],                8'h99, 8'h00, s_mo.wrap);
    cen_nxt = live[6][7:6] + {1'b0, s_yr.wrap};

    counted[0] = s_hs.val;
    counted[1] = {live[1][7],   s_se.val[6:0]};
    counted[2] = {live[2][7],   s_mi.val[6:0]};
    counted[3] = {live[3][7:6], s_hr.val[5:0]};
    counted[4] = {live[4][7:3], s_dw.val[2:0]};
    counted[5] = {live[5][7:6], s_dt.val[5:0]};
    counted[6] = {cen_nxt, live[6][5], s_mo.val[4:0]};
    counted[7] = s_yr.val;

    nxt = counted;
    if (wr_en) begin
      nxt          = live;
      nxt[wr_addr] = wr_data;
      nxt[0]       = 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) live <= RTC_RESET_IMG;
    else        live <= nxt;
  end

  // R6
  wr_clears_hund_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (live[0] == 8'h00));

  // R7
  stop_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !wr_en) |=> $stable(live));

  // R8
  keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((live & RTC_KEEP_MASK) == ($past(live) & RTC_KEEP_MASK)));
endmodule

// File: rtl/rtc_user_view.sv
module rtc_user_view
  import rtc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     freeze,
  input  logic [RTC_NREG-1:0][7:0] live,
  input  logic [RTC_AW-1:0]        rd_addr,
  output logic [7:0]               rd_data
);
  logic [RTC_NREG-1:0][7:0] shadow;

  generate
    for (genvar g = 0; g < RTC_NREG; g++) begin : g_byte
      logic [7:0] byte_q;
      always_ff @(posedge clk) begin
        if (!rst_n)       byte_q <= RTC_RESET_IMG[g];
        else if (!freeze) byte_q <= live[g];
      end
      assign shadow[g] = byte_q;
    end
  endgenerate

  assign rd_data = shadow[rd_addr];

  // R9
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(freeze) |-> (shadow == $past(shadow)));

  // R9
  transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(freeze) |-> (shadow == $past(live)));
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import rtc_pkg::*;
#(
  parameter int TICK_HZ = 32768,
  parameter int SUB_HZ  = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       freeze,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data
);
  logic                     sub_pulse;
  logic                     stopped;
  logic [RTC_NREG-1:0][7:0] live;

  rtc_subsec_div #(.TICK_HZ(TICK_HZ), .SUB_HZ(SUB_HZ)) div_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .run       (!stopped),
    .clear     (wr_en),
    .sub_pulse (sub_pulse)
  );

  rtc_time_core core_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sub_pulse (sub_pulse),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .live      (live),
    .stopped   (stopped)
  );

  rtc_user_view view_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .freeze  (freeze),
    .live    (live),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );
endmodule

// File: tb/bcd_calendar_clock_tb_top.sv
module bcd_calendar_clock_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TB_TICK = 250;
  localparam int TB_SUB  = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       freeze = 1'b0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;

  int n_chk = 0, n_fail = 0;
  bit auto_rd = 1'b1;
  bit done = 1'b0;
  string cur_req = "R1";

  bcd_calendar_clock #(.TICK_HZ(TB_TICK), .SUB_HZ(TB_SUB)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .freeze(freeze), .rd_addr(rd_addr), .rd_data(rd_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int m_h, m_s, m_mi, m_hr, m_dow, m_dt, m_mo, m_yr, m_cen, m_acc;
  bit m_stop, m_ofie, m_x6;
  bit [1:0] m_x3, m_x5;
  bit [4:0] m_x4;
  logic [7:0] sh [8];

  function automatic logic [7:0] tobcd(int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction
  function automatic int frombcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int dim(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] m_byte(int a);
    logic [7:0] t;
    case (a)
      0: t = tobcd(m_h);
      1: begin t = tobcd(m_s); t[7] = m_stop; end
      2: begin t = tobcd(m_mi); t[7] = m_ofie; end
      3: begin t = tobcd(m_hr); t[7:6] = m_x3; end
      4: t = {m_x4, 3'(m_dow)};
      5: begin t = tobcd(m_dt); t[7:6] = m_x5; end
      6: begin t = tobcd(m_mo); t[7:6] = 2'(m_cen); t[5] = m_x6; end
      default: t = tobcd(m_yr);
    endcase
    return t;
  endfunction

  task automatic m_reset();
    m_h = 0; m_s = 0; m_mi = 0; m_hr = 0; m_dow = 1; m_dt = 1; m_mo = 1;
    m_yr = 0; m_cen = 0; m_acc = 0; m_stop = 0; m_ofie = 0; m_x6 = 0;
    m_x3 = 0; m_x5 = 0; m_x4 = 0;
    for (int i = 0; i < 8; i++) sh[i] = m_byte(i);
  endtask

  task automatic m_write(logic [2:0] a, logic [7:0] d);
    case (a)
      3'd1: begin m_stop = d[7]; m_s = frombcd({1'b0, d[6:0]}); end
      3'd2: begin m_ofie = d[7]; m_mi = frombcd({1'b0, d[6:0]}); end
      3'd3: begin m_x3 = d[7:6]; m_hr = frombcd({2'b0, d[5:0]}); end
      3'd4: begin m_x4 = d[7:3]; m_dow = int'(d[2:0]); end
      3'd5: begin m_x5 = d[7:6]; m_dt = frombcd({2'b0, d[5:0]}); end
      3'd6: begin m_cen = int'(d[7:6]); m_x6 = d[5]; m_mo = frombcd({3'b0, d[4:0]}); end
      3'd7: m_yr = frombcd(d);
      default: ;
    endcase
    m_h = 0;
    m_acc = 0;
  endtask

  task automatic m_advance();
    m_h++;
    if (m_h == 100) begin
      m_h = 0; m_s++;
      if (m_s == 60) begin
        m_s = 0; m_mi++;
        if (m_mi == 60) begin
          m_mi = 0; m_hr++;
          if (m_hr == 24) begin
            m_hr = 0;
            m_dow = (m_dow == 7) ? 1 : m_dow + 1;
            m_dt++;
            if (m_dt > dim(m_mo, m_yr)) begin
              m_dt = 1; m_mo++;
              if (m_mo == 13) begin
                m_mo = 1; m_yr++;
                if (m_yr == 100) begin m_yr = 0; m_cen = (m_cen + 1) % 4; end
              end
            end
          end
        end
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      if (!freeze) for (int i = 0; i < 8; i++) sh[i] = m_byte(i);
      if (wr_en) m_write(wr_addr, wr_data);
      else if (tick && !m_stop) begin
        m_acc += TB_SUB;
        if (m_acc >= TB_TICK) begin m_acc -= TB_TICK; m_advance(); end
      end
    end
  end

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: addr %0d got %02h expected %02h at %0t", req, rd_addr, got, exp, $time);
    end
  endtask

  // R10: every cycle, rotating address, against the reference user copy
  always @(posedge clk) begin
    #1;
    if (auto_rd) rd_addr <= rd_addr + 3'd1;
  end
  always @(negedge clk) begin
    if (rst_n && !done) chk({cur_req, "/R10"}, rd_data, sh[rd_addr]);
  end

  task automatic step();
    @(posedge clk); #2;
  endtask
  task automatic idle(int n);
    tick = 0;
    for (int i = 0; i < n; i++) step();
  endtask
  task automatic wr(logic [2:0] a, logic [7:0] d);
    tick = 0; wr_en = 1; wr_addr = a; wr_data = d;
    step();
    wr_en = 0;
  endtask
  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      tick = (i % (gap + 1) == 0);
      step();
    end
    tick = 0;
  endtask
  task automatic peek(logic [2:0] a, logic [7:0] exp, string req);
    auto_rd = 0;
    rd_addr = a;
    @(negedge clk);
    chk(req, rd_data, exp);
    step();
    auto_rd = 1;
  endtask
  task automatic set_time(logic [7:0] hr, logic [7:0] dw, logic [7:0] dt,
                          logic [7:0] mo, logic [7:0] yr);
    wr(3'd7, yr); wr(3'd6, mo); wr(3'd5, dt); wr(3'd4, dw);
    wr(3'd3, hr); wr(3'd2, 8'h59); wr(3'd1, 8'h59);
  endtask

  initial begin
    repeat (4) step();
    rst_n = 1;
    step();
    cur_req = "R1";
    peek(3'd0, 8'h00, "R1"); peek(3'd4, 8'h01, "R1");
    peek(3'd5, 8'h01, "R1"); peek(3'd6, 8'h01, "R1"); peek(3'd7, 8'h00, "R1");

    cur_req = "R2";
    wr(3'd1, 8'h00);
    ticks(2, 0); idle(2); peek(3'd0, 8'h00, "R2");
    ticks(1, 0); idle(2); peek(3'd0, 8'h01, "R2");
    ticks(2, 0); idle(2); peek(3'd0, 8'h02, "R2");
    ticks(600, 2);
    wr(3'd1, 8'h00); ticks(250, 0); idle(2);
    peek(3'd0, 8'h00, "R2"); peek(3'd1, 8'h01, "R2");

    cur_req = "R6";
    wr(3'd0, 8'h55); idle(2); peek(3'd0, 8'h00, "R6");
    ticks(4, 0); wr(3'd2, 8'h00); ticks(2, 0); idle(2); peek(3'd0, 8'h00, "R6");

    cur_req = "R3";
    set_time(8'h23, 8'h07, 8'h10, 8'h05, 8'h21);
    ticks(260, 0); idle(2);
    peek(3'd0, 8'h04, "R3"); peek(3'd1, 8'h00, "R3"); peek(3'd2, 8'h00, "R3");
    peek(3'd3, 8'h00, "R3"); peek(3'd4, 8'h01, "R3"); peek(3'd5, 8'h11, "R3");

    cur_req = "R4";
    set_time(8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
    ticks(260, 0); idle(2); peek(3'd5, 8'h29, "R4"); peek(3'd6, 8'h02, "R4");
    set_time(8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
    ticks(260, 0); idle(2); peek(3'd5, 8'h01, "R4"); peek(3'd6, 8'h03, "R4");
    set_time(8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
    ticks(260, 0); idle(2); peek(3'd5, 8'h01, "R4"); peek(3'd6, 8'h03, "R4");
    set_time(8'h23, 8'h04, 8'h30, 8'h04, 8'h23);
    ticks(260, 0); idle(2); peek(3'd5, 8'h01, "R4"); peek(3'd6, 8'h05, "R4");
    set_time(8'h23, 8'h04, 8'h31, 8'h01, 8'h23);
    ticks(260, 0); idle(2); peek(3'd5, 8'h01, "R4"); peek(3'd6, 8'h02, "R4");

    cur_req = "R5";
    set_time(8'h23, 8'h05, 8'h31, 8'hD2, 8'h99);
    ticks(260, 0); idle(2); peek(3'd6, 8'h01, "R5"); peek(3'd7, 8'h00, "R5");
    set_time(8'h23, 8'h05, 8'h31, 8'h52, 8'h99);
    ticks(260, 0); idle(2); peek(3'd6, 8'h81, "R5"); peek(3'd7, 8'h00, "R5");

    cur_req = "R8";
    wr(3'd7, 8'h99); wr(3'd6, 8'h32); wr(3'd5, 8'h71); wr(3'd4, 8'hFF);
    wr(3'd3, 8'hE3); wr(3'd2, 8'hD9); wr(3'd1, 8'h59);
    ticks(260, 0); idle(2);
    peek(3'd2, 8'h80, "R8"); peek(3'd3, 8'hC0, "R8"); peek(3'd4, 8'hF9, "R8");
    peek(3'd5, 8'h41, "R8"); peek(3'd6, 8'h61, "R8"); peek(3'd7, 8'h00, "R8");

    cur_req = "R7";
    wr(3'd1, 8'h90); ticks(500, 0); idle(2);
    peek(3'd1, 8'h90, "R7"); peek(3'd0, 8'h00, "R7");
    wr(3'd1, 8'h10); ticks(260, 0); idle(2);
    peek(3'd1, 8'h11, "R7"); peek(3'd0, 8'h04, "R7");

    cur_req = "R9";
    wr(3'd1, 8'h05); idle(2);
    freeze = 1;
    ticks(260, 0);
    peek(3'd1, 8'h05, "R9"); peek(3'd0, 8'h00, "R9");
    wr(3'd7, 8'h42); idle(2);
    peek(3'd7, 8'h00, "R9");
    freeze = 0; idle(2);
    peek(3'd1, 8'h06, "R9"); peek(3'd0, 8'h00, "R9"); peek(3'd7, 8'h42, "R9");
    ticks(300, 1); idle(3);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule